// File: doc/BRIEF.md
# Low-Power Escape Sequence Transmitter

This block drives the two single-ended low-power lines of a serial data lane through an escape transaction. A strobe from the host starts the transaction: the lines leave the stop level, run through a fixed four-step entry pattern, and then carry a command byte. After the command, the block carries any number of payload bytes, one bit at a time. Each bit is sent as a one-hot mark on one line, and a space in which both lines are low always follows it. When the host has no byte ready at a byte boundary, the block drives a short exit pattern and returns to stop.

One command value puts the lane to sleep. After that command's last bit, both lines stay low for as long as the host wants. A wake request then raises a mark-1 for a separate, longer programmable time, after which the lane returns to stop. The durations come from two run-time inputs: one sets the dwell of every ordinary line state, and the other sets the wake-up mark. The dwell input is normally sized to meet the line timing, and the wake input to about a millisecond.

Top module: `esc_lp_tx`

## Requirements
- R1: After reset, and whenever `busy` is low, the lines sit at stop (`lp_p`=1, `lp_n`=1), and `data_ready` is low.
- R2: A `cmd_strobe` sampled while idle starts the entry in the next cycle. The line pairs ({`lp_p`,`lp_n`}) are 10, 00, 01, 00, and each one lasts the dwell time.
- R3: Each bit is a mark followed by a space. A 0 bit is the mark {`lp_p`,`lp_n`}=01 and a 1 bit is the mark 10. The space is 00, and both the mark and the space last the dwell time.
- R4: The command byte is sent first, right after the entry. Every byte is sent least significant bit first.
- R5: The dwell time is `hold_cycles` clock cycles, and a value of 0 acts as 1.
- R6: `data_ready` is high for exactly one cycle, the last cycle of the space after a byte's eighth bit. It is never high after the sleep command. If `data_valid` is high in that cycle, `data_in` is taken and its first mark starts in the next cycle.
- R7: If `data_valid` is low at a byte boundary, the lines go to 10 for the dwell time. They then return to stop and `busy` falls; the lines are never 11 while `busy` is high.
- R8: When the command equals parameter `ULPS_CODE` (default 8'h1E), no payload is accepted after it. After its last space the lines stay at 00 until `ulps_wake` is seen high.
- R9: In sleep, `ulps_wake` drives the lines to 10 from the next cycle for max(`wake_cycles`,1) cycles. The lines then return to stop.
- R10: `cmd_strobe` while busy and `ulps_wake` outside sleep have no effect on the lines or on the transaction under way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hold_cycles | input | HOLD_W | Dwell of each ordinary line state, in cycles |
| wake_cycles | input | WAKE_W | Length of the wake-up mark, in cycles |
| cmd_strobe | input | 1 | Starts a transaction when idle |
| cmd_byte | input | BYTE_W | Command sent after the entry pattern |
| data_in | input | BYTE_W | Payload byte |
| data_valid | input | 1 | Payload byte available |
| data_ready | output | 1 | Byte boundary; taken together with `data_valid` |
| ulps_wake | input | 1 | Leave sleep |
| lp_p | output | 1 | Positive low-power line |
| lp_n | output | 1 | Negative low-power line |
| busy | output | 1 | Transaction or sleep in progress |

## Verification
Several properties are checked on every cycle: each mark ends in a space, the stop level appears only when the block is not busy, the ready pulse lasts a single cycle, and an entry starts straight after a strobe. The assertions also check that sleep holds both lines low and that a wake request lifts the positive line in the next cycle. The full line waveform can only be judged against a trace of the expected values. The bench builds that trace in its own code for each transaction, so the scenarios show the ordering of the command and payload bits, the zero-dwell case, the number of bytes taken, and the wake length. They also show that strobes and wake requests sent at the wrong time are ignored.

// File: rtl/esc_lp_pkg.sv
package esc_lp_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_ENT_A, S_ENT_B, S_ENT_C, S_ENT_D,
    S_MARK, S_SPACE, S_EXIT, S_ULPS, S_WAKE
  } esc_state_e;

  // {p line, n line}
  typedef logic [1:0] lp_pair_t;

  localparam lp_pair_t LP_STOP  = 2'b11;
  localparam lp_pair_t LP_HIGHP = 2'b10;
  localparam lp_pair_t LP_HIGHN = 2'b01;
  localparam lp_pair_t LP_SPACE = 2'b00;

  // A one bit marks the p line, a zero bit marks the n line
  function automatic lp_pair_t mark_of(input logic b);
    return b ? LP_HIGHP : LP_HIGHN;
  endfunction

  function automatic lp_pair_t lines_of(input esc_state_e s, input logic b);
    case (s)
      S_IDLE:  return LP_STOP;
      S_ENT_A: return LP_HIGHP;
      S_ENT_C: return LP_HIGHN;
      S_MARK:  return mark_of(b);
      S_EXIT:  return LP_HIGHP;
      S_WAKE:  return LP_HIGHP;
      default: return LP_SPACE;
    endcase
  endfunction

endpackage

// File: rtl/esc_dwell.sv
module esc_dwell #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic [W-1:0] limit,
  output logic         done
);

  logic [W-1:0] cnt;
  logic [W-1:0] last;

  // A limit of zero behaves as a single cycle
  assign last = (limit == '0) ? '0 : limit - 1'b1;
  assign done = !clear && (cnt >= last);

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt <= '0;
    else if (clear || done)  cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/esc_shifter.sv
module esc_shifter #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_val,
  input  logic              shift,
  output logic              bit_now,
  output logic              last_bit
);

  localparam int IDX_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;

  logic [BYTE_W-1:0] sh;
  logic [IDX_W-1:0]  idx;

  assign bit_now  = sh[0];
  assign last_bit = (idx == IDX_W'(BYTE_W - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh  <= '0;
      idx <= '0;
    end else if (load) begin
      sh  <= load_val;
      idx <= '0;
    end else if (shift) begin
      sh  <= sh >> 1;
      idx <= idx + 1'b1;
    end
  end

endmodule

// File: rtl/esc_lp_tx.sv
module esc_lp_tx
  import esc_lp_pkg::*;
#(
  parameter int              HOLD_W    = 8,
  parameter int              WAKE_W    = 20,
  parameter int              BYTE_W    = 8,
  parameter logic [BYTE_W-1:0] ULPS_CODE = 8'h1E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HOLD_W-1:0] hold_cycles,
  input  logic [WAKE_W-1:0] wake_cycles,
  input  logic              cmd_strobe,
  input  logic [BYTE_W-1:0] cmd_byte,
  input  logic [BYTE_W-1:0] data_in,
  input  logic              data_valid,
  output logic              data_ready,
  input  logic              ulps_wake,
  output logic              lp_p,
  output logic              lp_n,
  output logic              busy
);

  esc_state_e        st, st_nx;
  logic [BYTE_W-1:0] cmd_q;
  logic              in_cmd;

  // Named internal events
  logic     hold_done, wake_done, hold_clear, wake_clear;
  logic     sh_load, sh_shift, bit_now, last_bit;
  logic     byte_end, ulps_hit, take;
  logic [BYTE_W-1:0] sh_val;
  lp_pair_t lines;

  esc_dwell #(.W(HOLD_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .clear(hold_clear),
    .limit(hold_cycles), .done(hold_done)
  );

  esc_dwell #(.W(WAKE_W)) u_wake (
    .clk(clk), .rst_n(rst_n), .clear(wake_clear),
    .limit(wake_cycles), .done(wake_done)
  );

  esc_shifter #(.BYTE_W(BYTE_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(sh_load), .load_val(sh_val),
    .shift(sh_shift), .bit_now(bit_now), .last_bit(last_bit)
  );

  assign hold_clear = (st == S_IDLE) || (st == S_ULPS) || (st == S_WAKE);
  assign wake_clear = (st != S_WAKE);
  assign byte_end   = (st == S_SPACE) && hold_done && last_bit;
  assign ulps_hit   = in_cmd && (cmd_q == ULPS_CODE);
  assign data_ready = byte_end && !ulps_hit;
  assign take       = data_ready && data_valid;

  always_comb begin
    st_nx    = st;
    sh_load  = 1'b0;
    sh_shift = 1'b0;
    sh_val   = data_in;
    case (st)
      S_IDLE:  if (cmd_strobe) st_nx = S_ENT_A;
      S_ENT_A: if (hold_done) st_nx = S_ENT_B;
      S_ENT_B: if (hold_done) st_nx = S_ENT_C;
      S_ENT_C: if (hold_done) st_nx = S_ENT_D;
      S_ENT_D: if (hold_done) begin
        st_nx   = S_MARK;
        sh_load = 1'b1;
        sh_val  = cmd_q;
      end
      S_MARK:  if (hold_done) st_nx = S_SPACE;
      S_SPACE: if (hold_done) begin
        if (!last_bit) begin
          st_nx    = S_MARK;
          sh_shift = 1'b1;
        end else if (ulps_hit) begin
          st_nx = S_ULPS;
        end else if (take) begin
          st_nx   = S_MARK;
          sh_load = 1'b1;
        end else begin
          st_nx = S_EXIT;
        end
      end
      S_EXIT:  if (hold_done) st_nx = S_IDLE;
      S_ULPS:  if (ulps_wake) st_nx = S_WAKE;
      S_WAKE:  if (wake_done) st_nx = S_IDLE;
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cmd_q  <= '0;
      in_cmd <= 1'b0;
    end else begin
      st <= st_nx;
      if (st == S_IDLE && cmd_strobe) cmd_q <= cmd_byte;
      if (st == S_ENT_D && hold_done) in_cmd <= 1'b1;
      else if (byte_end)              in_cmd <= 1'b0;
    end
  end

  assign lines = lines_of(st, bit_now);
  assign lp_p  = lines[1];
  assign lp_n  = lines[0];
  assign busy  = (st != S_IDLE);

  // ---------------- assertions ----------------
  assert_idle_stop_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (lp_p && lp_n && !data_ready));

  assert_entry_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_strobe) |=> (lp_p && !lp_n));

  assert_mark_then_space_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_MARK && hold_done) |=> (!lp_p && !lp_n));

  assert_ready_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    data_ready |=> !data_ready);

  assert_busy_not_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(lp_p && lp_n));

  assert_sleep_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ULPS && !ulps_wake) |=> (!lp_p && !lp_n && busy));

  assert_wake_mark_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ULPS && ulps_wake) |=> (lp_p && !lp_n));

  assert_strobe_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_strobe) |=> $stable(cmd_q));

endmodule

// File: tb/esc_lp_tx_test.sv
`timescale 1ns/1ps
module esc_lp_tx_test;

  localparam int HOLD_W = 8;
  localparam int WAKE_W = 20;
  localparam logic [7:0] SLEEP_CMD = 8'h1E;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [HOLD_W-1:0] hold_cycles = '0;
  logic [WAKE_W-1:0] wake_cycles = '0;
  logic cmd_strobe = 1'b0;
  logic [7:0] cmd_byte = '0;
  logic [7:0] data_in = '0;
  logic data_valid = 1'b0;
  logic data_ready;
  logic ulps_wake = 1'b0;
  logic lp_p, lp_n, busy;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [1:0] trace[$];
  logic [1:0] expq[$];

  always #2.5 clk = ~clk;

  esc_lp_tx uut (
    .clk(clk), .rst_n(rst_n), .hold_cycles(hold_cycles), .wake_cycles(wake_cycles),
    .cmd_strobe(cmd_strobe), .cmd_byte(cmd_byte), .data_in(data_in),
    .data_valid(data_valid), .data_ready(data_ready), .ulps_wake(ulps_wake),
    .lp_p(lp_p), .lp_n(lp_n), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic push_n(input int n, input logic [1:0] v);
    for (int i = 0; i < n; i++) expq.push_back(v);
  endtask

  // Expected line trace, rebuilt from the requirements
  task automatic push_byte(input logic [7:0] b, input int n);
    for (int k = 0; k < 8; k++) begin
      push_n(n, b[k] ? 2'b10 : 2'b01);   // R3 marks, R4 LSB first
      push_n(n, 2'b00);                  // R3 space
    end
  endtask

  task automatic run_txn(input logic [7:0] cmd, input int nb, input int hold,
                         input int wk, input int dly, input bit poke);
    logic [7:0] bd[8];
    bit sleep;
    int n, sent, cu, tix, first_bad;
    bit hs;
    for (int i = 0; i < 8; i++) bd[i] = 8'($urandom);
    sleep = (cmd == SLEEP_CMD);
    n = eff(hold);
    cu = 20 * n + dly - 2;
    sent = 0;
    @(posedge clk); #1;
    hold_cycles = HOLD_W'(hold);
    wake_cycles = WAKE_W'(wk);
    cmd_byte = cmd;
    cmd_strobe = 1'b1;
    data_valid = (nb > 0);
    data_in = bd[0];
    @(posedge clk); #1;
    cmd_strobe = 1'b0;
    cmd_byte = ~cmd;
    trace.delete();
    for (int cyc = 0; cyc < 6000; cyc++) begin
      @(negedge clk);
      if (!busy) break;
      trace.push_back({lp_p, lp_n});
      hs = data_ready && data_valid;
      tix = trace.size() - 1;
      @(posedge clk); #1;
      if (hs) begin
        sent++;
        if (sent < nb) data_in = bd[sent];
        else data_valid = 1'b0;
      end
      ulps_wake  = sleep && (tix == cu);
      cmd_strobe = poke && (tix == 3);     // R10 strobe while busy
    end
    ulps_wake = 1'b0;
    cmd_strobe = 1'b0;
    check(lp_p && lp_n && !busy, "R7", "stop after transaction", {lp_p, lp_n}, 3);

    expq.delete();
    push_n(n, 2'b10); push_n(n, 2'b00); push_n(n, 2'b01); push_n(n, 2'b00);  // R2
    push_byte(cmd, n);
    if (sleep) begin
      push_n(dly, 2'b00);          // R8
      push_n(eff(wk), 2'b10);      // R9
    end else begin
      for (int j = 0; j < nb; j++) push_byte(bd[j], n);   // R6
      push_n(n, 2'b10);            // R7
    end
    check(trace.size() == expq.size(), "R5", "trace length", trace.size(), expq.size());
    first_bad = -1;
    for (int i = 0; i < trace.size() && i < expq.size(); i++)
      if (first_bad < 0 && trace[i] != expq[i]) first_bad = i;
    if (first_bad >= 0)
      check(1'b0, "R2 R3 R4 R8 R9", "line pair mismatch", trace[first_bad], expq[first_bad]);
    else
      check(1'b1, "R2 R3 R4", "line trace", 0, 0);
    check(sent == (sleep ? 0 : nb), "R6", "bytes taken", sent, sleep ? 0 : nb);
    data_valid = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(lp_p && lp_n, "R1", "reset lines", {lp_p, lp_n}, 3);
    check(!busy && !data_ready, "R1", "reset busy/ready", {busy, data_ready}, 0);

    // R10: wake request while idle
    @(posedge clk); #1 ulps_wake = 1'b1;
    repeat (3) @(posedge clk);
    #1 ulps_wake = 1'b0;
    @(negedge clk);
    check(lp_p && lp_n && !busy, "R10", "wake while idle ignored", {busy, lp_p, lp_n}, 3);

    run_txn(8'hA5, 0, 1, 0, 0, 1'b0);          // R7 command only
    run_txn(8'h3C, 1, 0, 0, 0, 1'b0);          // R5 zero dwell
    run_txn(8'h81, 2, 2, 0, 0, 1'b1);          // R10 strobe mid-flight
    run_txn(SLEEP_CMD, 2, 1, 7, 5, 1'b0);      // R8 R9 with valid held high
    run_txn(SLEEP_CMD, 0, 3, 0, 2, 1'b0);      // R9 zero wake acts as one
    for (int r = 0; r < 12; r++) begin
      logic [7:0] c;
      c = 8'($urandom);
      if (c == SLEEP_CMD) c = c ^ 8'h01;
      run_txn(c, int'($urandom % 4), int'($urandom % 5), 0, 0, 1'b0);
    end
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule